// File: doc/BRIEF.md
# Winding Current Chopper

This block is the timing core of fixed-frequency current regulation for one bridge. A free-running period counter starts a new chopping period at a fixed 50 kHz rate. At the start of each period the drive is switched on, provided the bridge is enabled and the scale setting allows current. An external comparator reports when the sensed winding current has reached the threshold. The threshold is the sense voltage times five, measured against a scaled reference. This block ignores that comparator for a fixed 3.75 µs blanking interval after the drive turns on. A trip seen after blanking ends drive at once and requests decay until the next period starts.

A 2-bit scale code selects the reference fraction sent to the external DAC, and one of its codes switches the bridge off. The clock frequency, the chopping rate and the blanking duration are parameters. The period and blanking cycle counts are derived from them, and the blanking count is clamped so that every period keeps at least one sensing cycle.

Top module: `winding_chopper`

## Requirements
- R1: Reset clears the period counter and any latched trip, so the first cycle after reset release is cycle 0 of a period with drive on (when enabled and scale code is not 11).
- R2: The period is PERIOD_CYC = CLK_HZ / PWM_HZ cycles, and the drive turns on again in cycle 0 of every period, whatever happened in the previous period.
- R3: During cycles 0 to BLANK_CYC-1 of a period, `trip` has no effect: `drive_on` stays high and `decay_req` stays low. This makes BLANK_CYC cycles the minimum on time.
- R4: From cycle BLANK_CYC on, `trip` high turns `drive_on` low and `decay_req` high in the same cycle.
- R5: Once tripped, `drive_on` stays low and `decay_req` stays high until the end of the period, even after `trip` falls.
- R6: A `trip` held high across a period start is ignored until blanking ends, and drive stops in cycle BLANK_CYC.
- R7: `ref_pct` decodes `scale_code` as 00 to 100, 01 to 71 and 10 to 38, with `bridge_off` low.
- R8: Scale code 11 gives `ref_pct` = 0, `bridge_off` high, and `drive_on` and `decay_req` both low, with or without trip.
- R9: With `bridge_en` low, `drive_on` and `decay_req` are low. The period counter and the trip latch keep running, so re-enabling follows the existing period grid.
- R10: BLANK_CYC = CLK_HZ·BLANK_NS/10^9. If that value reaches PERIOD_CYC, it is clamped to PERIOD_CYC-1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scale_code | input | 2 | Current scale: 00 full, 01 71 %, 10 38 %, 11 bridge off |
| bridge_en | input | 1 | Bridge enable (external speed PWM) |
| trip | input | 1 | Current comparator trip |
| drive_on | output | 1 | Drive the winding |
| decay_req | output | 1 | Chopped: decay for rest of period |
| ref_pct | output | 7 | Reference fraction in percent for the DAC |
| bridge_off | output | 1 | Scale code disables the bridge |

## Verification
The bench builds two instances at a 1 MHz clock and a 50 kHz rate. This gives a 20-cycle period, so whole periods, wraps and trips latched across a period boundary fit in a few dozen cycles. The main instance uses the nominal 3.75 µs blanking, which gives 3 cycles. The second instance uses a 30 µs blanking request, which brings the clamp to 19 cycles within reach. In that instance, a held trip leaves exactly one chopped cycle per period.

// File: rtl/chop_pkg.sv
package chop_pkg;

    typedef struct packed {
        logic [6:0] pct;
        logic       off;
    } scale_t;

    // Scale code to reference fraction; code 3 disables the bridge.
    function automatic scale_t decode_scale(input logic [1:0] code);
        scale_t s;
        s.off = 1'b0;
        case (code)
            2'd0:    s.pct = 7'd100;
            2'd1:    s.pct = 7'd71;
            2'd2:    s.pct = 7'd38;
            default: begin
                s.pct = 7'd0;
                s.off = 1'b1;
            end
        endcase
        return s;
    endfunction

endpackage

// File: rtl/chop_period_timer.sv
module chop_period_timer #(
    parameter int PERIOD_CYC = 2000,
    parameter int BLANK_CYC  = 375,
    localparam int CW = (PERIOD_CYC > 2) ? $clog2(PERIOD_CYC) : 1
) (
    input  logic clk,
    input  logic rst_n,
    output logic period_end,
    output logic blank_win
);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } tmr_t;

    tmr_t st_d, st_q;

    assign period_end = (st_q.cnt == CW'(PERIOD_CYC - 1));

    always_comb begin
        st_d = st_q;
        if (period_end) st_d.cnt = '0;
        else            st_d.cnt = st_q.cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    generate
        if (BLANK_CYC == 0) begin : g_noblank
            assign blank_win = 1'b0;
        end else begin : g_blank
            assign blank_win = (st_q.cnt < CW'(BLANK_CYC));
        end
    endgenerate

    // R2
    cnt_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        period_end |=> (st_q.cnt == '0));

    // R2
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !period_end |=> (st_q.cnt == $past(st_q.cnt) + 1'b1));

endmodule

// File: rtl/chop_trip_latch.sv
module chop_trip_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic period_end,
    input  logic blank_win,
    input  logic trip,
    output logic chop_now
);

    typedef struct packed {
        logic tripped;
    } lat_t;

    lat_t st_d, st_q;
    logic hit;

    assign hit      = trip & ~blank_win;
    assign chop_now = st_q.tripped | hit;

    always_comb begin
        st_d = st_q;
        if (period_end) st_d.tripped = 1'b0;
        else if (hit)   st_d.tripped = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R5
    trip_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.tripped && !period_end) |=> st_q.tripped);

    // R2
    period_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        period_end |=> !st_q.tripped);

endmodule

// File: rtl/chop_scale_decode.sv
module chop_scale_decode
    import chop_pkg::*;
(
    input  logic [1:0] scale_code,
    output logic [6:0] ref_pct,
    output logic       bridge_off
);

    scale_t s;

    always_comb begin
        s          = decode_scale(scale_code);
        ref_pct    = s.pct;
        bridge_off = s.off;
    end

    // R7
    always_comb begin
        ref_range_chk: assert (ref_pct <= 7'd100);
    end

endmodule

// File: rtl/winding_chopper.sv
module winding_chopper #(
    parameter int CLK_HZ   = 100_000_000,
    parameter int PWM_HZ   = 50_000,
    parameter int BLANK_NS = 3750,
    localparam int PERIOD_CYC = CLK_HZ / PWM_HZ,
    localparam int BLANK_RAW  = ((CLK_HZ / 1000) * BLANK_NS) / 1_000_000,
    localparam int BLANK_CYC  = (BLANK_RAW >= PERIOD_CYC) ? PERIOD_CYC - 1 : BLANK_RAW
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] scale_code,
    input  logic       bridge_en,
    input  logic       trip,
    output logic       drive_on,
    output logic       decay_req,
    output logic [6:0] ref_pct,
    output logic       bridge_off
);

    logic period_end, blank_win, chop_now, en_ok;

    chop_period_timer #(
        .PERIOD_CYC(PERIOD_CYC),
        .BLANK_CYC (BLANK_CYC)
    ) tmr_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .period_end(period_end),
        .blank_win (blank_win)
    );

    chop_trip_latch lat_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .period_end(period_end),
        .blank_win (blank_win),
        .trip      (trip),
        .chop_now  (chop_now)
    );

    chop_scale_decode dec_i (
        .scale_code(scale_code),
        .ref_pct   (ref_pct),
        .bridge_off(bridge_off)
    );

    assign en_ok     = bridge_en & ~bridge_off;
    assign drive_on  = en_ok & ~chop_now;
    assign decay_req = en_ok & chop_now;

    // R3
    min_on_time_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_ok && blank_win) |-> drive_on);

    // R8
    off_no_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bridge_off |-> (!drive_on && !decay_req && ref_pct == 7'd0));

    // R9
    disabled_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bridge_en |-> (!drive_on && !decay_req));

endmodule

// File: tb/winding_chopper_tb.sv
module winding_chopper_tb_top;

    localparam int CLK_PERIOD = 10;
    // Bench-side figures from the requirements: 1 MHz / 50 kHz = 20 cycles,
    // 3.75 us at 1 MHz = 3 cycles, 30 us clamps to 20 - 1 = 19 cycles.
    localparam int PER  = 20;
    localparam int BLK  = 3;
    localparam int BLK2 = 19;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] code_i = 2'd0;
    logic       en_i = 1'b0;
    logic       trip_i = 1'b0;
    logic       drv, dec, off, drv2, dec2, off2;
    logic [6:0] pct, pct2;

    always #(CLK_PERIOD / 2) clk = ~clk;

    winding_chopper #(.CLK_HZ(1_000_000), .PWM_HZ(50_000), .BLANK_NS(3750)) dut_i (
        .clk(clk), .rst_n(rst_n), .scale_code(code_i), .bridge_en(en_i), .trip(trip_i),
        .drive_on(drv), .decay_req(dec), .ref_pct(pct), .bridge_off(off));

    winding_chopper #(.CLK_HZ(1_000_000), .PWM_HZ(50_000), .BLANK_NS(30000)) dut_clamp_i (
        .clk(clk), .rst_n(rst_n), .scale_code(code_i), .bridge_en(en_i), .trip(trip_i),
        .drive_on(drv2), .decay_req(dec2), .ref_pct(pct2), .bridge_off(off2));

    typedef struct {
        logic       d;
        logic       c;
        logic [6:0] p;
        logic       o;
        logic       d2;
        logic       c2;
        string      tag;
    } exp_t;

    exp_t q[$];
    int   checks = 0;
    int   fails = 0;
    int   ph = 0;
    logic tr = 1'b0, tr2 = 1'b0;
    logic done = 1'b0;

    task automatic do_reset();
        rst_n  = 1'b0;
        trip_i = 1'b0;
        en_i   = 1'b0;
        code_i = 2'd0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        ph  = 0;
        tr  = 1'b0;
        tr2 = 1'b0;
    endtask

    task automatic step(input logic t, input logic e, input logic [1:0] c, input string tag);
        exp_t x;
        logic act, hit, hit2;
        act  = e && (c != 2'd3);
        hit  = t && (ph >= BLK);
        hit2 = t && (ph >= BLK2);
        x.d  = act && !tr && !hit;
        x.c  = act && (tr || hit);
        x.d2 = act && !tr2 && !hit2;
        x.c2 = act && (tr2 || hit2);
        x.p  = (c == 2'd0) ? 7'd100 : (c == 2'd1) ? 7'd71 : (c == 2'd2) ? 7'd38 : 7'd0;
        x.o  = (c == 2'd3);
        x.tag = tag;
        trip_i = t;
        en_i   = e;
        code_i = c;
        q.push_back(x);
        tr  = (ph == PER - 1) ? 1'b0 : (tr || hit);
        tr2 = (ph == PER - 1) ? 1'b0 : (tr2 || hit2);
        ph  = (ph == PER - 1) ? 0 : ph + 1;
        @(negedge clk);
    endtask

    // Monitor: compares mid-cycle, away from the active edge.
    initial begin
        forever begin
            @(negedge clk);
            #2;
            if (q.size() > 0) begin
                exp_t x;
                x = q.pop_front();
                checks++;
                if ({drv, dec, pct, off} !== {x.d, x.c, x.p, x.o}) begin
                    fails++;
                    $display("FAIL %s: drive=%b decay=%b ref=%0d off=%b expected %b %b %0d %b",
                             x.tag, drv, dec, pct, off, x.d, x.c, x.p, x.o);
                end
                checks++;
                if ({drv2, dec2} !== {x.d2, x.c2}) begin
                    fails++;
                    $display("FAIL R10 (%s): clamp drive=%b decay=%b expected %b %b",
                             x.tag, drv2, dec2, x.d2, x.c2);
                end
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        do_reset();
        // R1: first cycle after release is period start, drive on despite trip
        step(1'b1, 1'b1, 2'd0, "R1");
        step(1'b1, 1'b1, 2'd0, "R1");
        for (int k = 0; k < 18; k++) step(1'b0, 1'b1, 2'd0, "R2");
        // R4 / R5 / R2: single trip pulse mid-period, three periods
        for (int p = 0; p < 3; p++)
            for (int k = 0; k < PER; k++)
                step(k == 10, 1'b1, 2'd0, (k < 10) ? "R2" : (k == 10) ? "R4" : "R5");
        // R3 / R6: trip held across period starts
        for (int k = 0; k < 2 * PER; k++)
            step(1'b1, 1'b1, 2'd0, (k % PER < BLK) ? "R3" : "R6");
        // R7: reference codes
        for (int c = 1; c < 3; c++)
            for (int k = 0; k < PER; k++) step(1'b0, 1'b1, 2'(c), "R7");
        step(1'b0, 1'b1, 2'd0, "R7");
        // R8: disable code, with and without trip
        for (int k = 0; k < PER; k++) step(k > 8, 1'b1, 2'd3, "R8");
        // R9: disabled while tripping, then re-enabled mid-period
        for (int k = 0; k < 25; k++) step(1'b1, 1'b0, 2'd0, "R9");
        for (int k = 0; k < 30; k++) step(1'b0, 1'b1, 2'd0, "R9");
        // R1: reset mid-period after a latched trip
        while (ph != 12) step(ph == 8, 1'b1, 2'd0, "R5");
        do_reset();
        step(1'b0, 1'b1, 2'd0, "R1");
        step(1'b0, 1'b1, 2'd0, "R1");
        for (int k = 0; k < 12; k++) step(1'b0, 1'b1, 2'd0, "R2");
        step(1'b0, 1'b0, 2'd0, "R9");
        @(negedge clk);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule